// File: doc/BRIEF.md
# Port Replicator With Direction Register

This block reproduces eight host port lines as eight external outputs, each with its own output enable. While the select strobe is high the external outputs follow the host bus directly. When the select strobe falls, every output freezes at its current level. Each frozen output is either driven or released to high impedance, as set by an 8-bit direction register.

The same bus loads the direction register. The order of the two strobes picks the operation at the falling edge of select. If the clock strobe is already low, the cycle is a register write, committed when select rises. If the clock strobe is high, the cycle is a memory-access phase, which only latches the outputs and applies the enables. A power-fail input blocks register writes and drives an active-low flag. Both strobes and the power-fail input are synchronised to the system clock before any edge is detected.

Top module: `port_replicator`

## Requirements
- R1: While the synchronised select is high, `out_o` equals `bus_i` and every bit of `oe_o` is 1.
- R2: While the synchronised select is low, `out_o` holds the `bus_i` value from the last cycle in which select was high, whatever `bus_i` does afterwards.
- R3: While the synchronised select is low, `oe_o[i]` is the inverse of direction bit i, so bit 0 governs `out_o[0]` and bit 7 governs `out_o[7]`. A direction bit of 1 releases its output.
- R4: If `stb_i` is low when select falls, the cycle is a register write, and the `bus_i` value in the cycle where select rises is stored into the direction register.
- R5: During a register write, `oe_o` follows the old register contents. The new contents take effect from the next falling edge of select.
- R6: If `stb_i` is high when select falls, the direction register is left unchanged, whatever value is on the bus.
- R7: While `pwr_fail_i` is high, register writes are blocked and `fail_flag_no` is 0. Otherwise `fail_flag_no` is 1.
- R8: After reset the direction register is all zeros (every output driven) and `fail_flag_no` is 1.
- R9: `sel_i`, `stb_i` and `pwr_fail_i` each pass through a synchroniser of `SYNC_STAGES` flops before they are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_i | input | 8 | Host port lines |
| sel_i | input | 1 | Select strobe (high: transparent) |
| stb_i | input | 1 | Clock strobe, sampled at the falling edge of select |
| pwr_fail_i | input | 1 | Power-fail indication, active high |
| out_o | output | 8 | External output levels |
| oe_o | output | 8 | Per-output drive enables (1 = driven) |
| fail_flag_no | output | 1 | Power-fail flag, active low |

## Verification
On every cycle, assertions check three things. Held levels and enables do not move during a select-low phase. The direction register changes only in the cycle after a select rise that ends a write with power good. A select fall with the clock strobe high always selects memory-access mode. The bench sweeps all bus values for transparency and latching, and a set of direction patterns including all zeros, all ones and walking ones. Three properties need whole strobe sequences, so only the bench scenarios can show them: the delayed effect of a new direction value, a power-fail write being discarded, and a memory-access phase leaving the register untouched.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic {
    MODE_MEM = 1'b0,
    MODE_DIR = 1'b1
  } pr_mode_e;
endpackage

// File: rtl/pr_sync.sv
module pr_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[s] <= RST_VAL;
        else if (s == 0) st_q[s] <= d_i;
        else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pr_edge_ctrl.sv
module pr_edge_ctrl
  import pr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_s_i,
  input  logic     stb_s_i,
  output logic     fall_o,
  output logic     rise_o,
  output pr_mode_e mode_o
);
  logic     sel_d_q;
  pr_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_d_q <= 1'b1;
      mode_q  <= MODE_MEM;
    end else begin
      sel_d_q <= sel_s_i;
      if (fall_o) mode_q <= stb_s_i ? MODE_MEM : MODE_DIR;
    end
  end

  assign fall_o = sel_d_q & ~sel_s_i;
  assign rise_o = ~sel_d_q & sel_s_i;
  assign mode_o = mode_q;

  // R6: strobe high at select fall always means memory access
  p_mem_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && stb_s_i) |=> (mode_o == MODE_MEM));
  p_dir_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && !stb_s_i) |=> (mode_o == MODE_DIR));
endmodule

// File: rtl/pr_dir_reg.sv
module pr_dir_reg
  import pr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  pr_mode_e     mode_i,
  input  logic         pf_s_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] dir_q;
  logic         commit;

  assign commit = rise_i & (mode_i == MODE_DIR) & ~pf_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= '0;
    else if (commit) dir_q <= bus_i;
  end

  assign dir_o = dir_q;

  p_commit_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_q) |-> $past(rise_i && mode_i == MODE_DIR));
  p_pf_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_s_i |=> $stable(dir_q));
endmodule

// File: rtl/port_replicator.sv
module port_replicator #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_i,
  input  logic         sel_i,
  input  logic         stb_i,
  input  logic         pwr_fail_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic         fail_flag_no
);
  import pr_pkg::*;

  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw, syn;
  logic             sel_s, stb_s, pf_s;
  logic             fall, rise;
  pr_mode_e         mode;
  logic [W-1:0]     dir, hold_q;

  assign raw = {pwr_fail_i, stb_i, sel_i};

  pr_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );
  assign {pf_s, stb_s, sel_s} = syn;

  pr_edge_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_s_i(sel_s), .stb_s_i(stb_s),
    .fall_o(fall), .rise_o(rise), .mode_o(mode)
  );

  pr_dir_reg #(.W(W)) u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .mode_i(mode),
    .pf_s_i(pf_s), .bus_i(bus_i), .dir_o(dir)
  );

  // track host lines while transparent; frozen once select is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (sel_s) hold_q <= bus_i;
  end

  assign out_o        = sel_s ? bus_i : hold_q;
  assign oe_o         = sel_s ? '1 : ~dir;
  assign fail_flag_no = ~pf_s;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_s && $past(!sel_s)) |-> $stable(out_o));
  p_enable_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_s && $past(!sel_s)) |-> $stable(oe_o));
  p_fall_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |-> (mode == $past(mode)));
endmodule

// File: tb/port_replicator_bench.sv
module port_replicator_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus = '0;
  logic       sel = 1'b1, stb = 1'b1, pf = 1'b0;
  logic [7:0] out, oe;
  logic       flag_n;

  int checks = 0, fails = 0;
  logic [7:0] model_dir = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_replicator u_port_replicator (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .sel_i(sel), .stb_i(stb),
    .pwr_fail_i(pf), .out_o(out), .oe_o(oe), .fail_flag_no(flag_n)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dir_write(logic [7:0] val);
    stb = 1'b0; wt(4);
    sel = 1'b0; wt(4);
    bus = val; wt(4);
    chk("R5 old enables during write", oe, ~model_dir);
    sel = 1'b1; wt(4);
    stb = 1'b1; wt(1);
    if (!pf) model_dir = val;
  endtask

  task automatic mem_acc(logic [7:0] v);
    stb = 1'b1; bus = v; sel = 1'b1; wt(4);
    sel = 1'b0; wt(4);
    chk("R3 enables from direction", oe, ~model_dir);
    chk("R2 latched level", out, v);
    bus = ~v; wt(2);
    chk("R2 held after bus change", out, v);
    sel = 1'b1; wt(4);
    chk("R1 transparent", out, ~v);
    chk("R1 all enabled", oe, 8'hFF);
  endtask

  initial begin
    wt(2);
    chk("R8 reset flag", {7'd0, flag_n}, 8'h01);
    chk("R8 reset enables", oe, 8'hFF);
    rst_n = 1'b1; wt(4);
    mem_acc(8'h5A);
    // R1 sweep: every value passes straight through
    for (int v = 0; v < 256; v++) begin
      bus = v[7:0]; wt(1);
      chk("R1 sweep", out, v[7:0]);
    end
    // R2 sweep of latched values
    for (int v = 0; v < 256; v += 17) mem_acc(v[7:0]);
    // R4/R5/R3 direction patterns incl. walking ones
    for (int b = 0; b < 8; b++) begin
      dir_write(8'(1 << b));
      mem_acc(8'hC3);
    end
    dir_write(8'hFF); mem_acc(8'h3C);
    dir_write(8'h00); mem_acc(8'h96);
    dir_write(8'hA5);
    // R6: memory access with arbitrary bus leaves register alone
    for (int v = 0; v < 256; v += 51) mem_acc(v[7:0]);
    chk("R6 register kept", model_dir, 8'hA5);
    // R7: power fail blocks a write and lowers the flag
    pf = 1'b1; wt(4);
    chk("R7 flag low", {7'd0, flag_n}, 8'h00);
    dir_write(8'h0F);
    pf = 1'b0; wt(4);
    chk("R7 flag recovers", {7'd0, flag_n}, 8'h01);
    mem_acc(8'h11);
    chk("R7 blocked write", model_dir, 8'hA5);
    // R9: select change is not seen before the synchroniser delay
    sel = 1'b0; bus = 8'h77; @(posedge clk); #1;
    chk("R9 sync latency", oe, 8'hFF);
    wt(4);
    chk("R9 after sync", oe, ~model_dir);
    sel = 1'b1; wt(4);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule